// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits between a processor-side window into PCI configuration space and the logic that runs configuration cycles on the bus. Each access in the window carries only sixteen address bits. The upper half of the configuration address comes from a mapping value that software writes ahead of time. From the joined 32-bit value the block takes a one-hot device-select field, a function number and a dword register index. It then builds a type-0 configuration word with the enable bit set and the local bus number inserted.

When a translation fails, no configuration cycle may happen. This is the case when no device-select bit is set, when the mapping value asks for a type-1 cycle, or when the access size or alignment is illegal. A failed read returns all ones across the width of the access, and a failed write is dropped. Every accepted request gets its result one clock later. The block is a two-state machine: `ST_IDLE` (no result pending) and `ST_RESP` (a result is presented). A request moves the machine into `ST_RESP`, or keeps it there. A cycle without a request moves it back to `ST_IDLE`.

Top module: `pci_cfg_xlate`

## Requirements
- R1: The 32-bit configuration address is `{map_cfg[15:0], req_addr[15:0]}`. Its bits [31:11] form the device-select field.
- R2: When `map_cfg[16]` is 1 (type-1 request), the translation is invalid.
- R3: The device number is the position of the lowest set bit in configuration address bits [31:11], counted from bit 11. Bit 11 gives device 0 and bit 31 gives device 20.
- R4: When several device-select bits are set, the lowest one decides the device number, and the translation stays valid.
- R5: A device-select field of all zeros makes the translation invalid.
- R6: A valid result word has bit 31 = 1, bits [30:24] = 0, bits [23:16] = `bus_num`, bits [15:11] = device, bits [10:8] = configuration address bits [10:8], bits [7:2] = configuration address bits [7:2], and bits [1:0] = 0.
- R7: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. Back-to-back requests give back-to-back results, and `rsp_valid` is low in every other cycle.
- R8: An invalid read returns `rd_data` = 0x000000FF for size code 0, 0x0000FFFF for code 1, and 0xFFFFFFFF for codes 2 and 3.
- R9: An invalid access raises neither `cfg_wr_en` nor `cfg_rd_en`. An invalid write is therefore discarded.
- R10: The size codes are: 0 = one byte, 1 = two bytes (needs `req_addr[0]` = 0), 2 = four bytes (needs `req_addr[1:0]` = 0), 3 = illegal. Any violation is invalid. On a valid access, `cfg_be` holds the lane mask (0x1, 0x3 or 0xF) shifted left by `req_addr[1:0]`. On an invalid access it is 0.
- R11: A valid read raises `cfg_rd_en` and returns `bus_rdata` unchanged on `rd_data`. A valid write raises `cfg_wr_en` with `cfg_wdata` equal to the request's `req_wdata`.
- R12: During and after a synchronous active-low reset, `rsp_valid`, `cfg_wr_en` and `cfg_rd_en` are low until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset inside the configuration window |
| req_size | input | 2 | Access size code (R10) |
| req_wdata | input | 32 | Write data |
| map_cfg | input | 17 | Bits [15:0] form the upper address half; bit 16 requests type 1 |
| bus_num | input | 8 | Static local bus number |
| bus_rdata | input | 32 | Read data returned by the configuration cycle |
| rsp_valid | output | 1 | Result presented this cycle |
| cfg_ok | output | 1 | Translation valid |
| cfg_addr | output | 32 | Type-0 configuration word |
| cfg_be | output | 4 | Byte lanes of the access |
| cfg_wr_en | output | 1 | Run a configuration write |
| cfg_rd_en | output | 1 | Run a configuration read |
| cfg_wdata | output | 32 | Write data for the cycle |
| rd_data | output | 32 | Read data returned to the processor |

## Verification
The bench places the device-select bit at both ends of the field: bit 11 for device 0 and bit 31 for device 20. A priority encoder that is off by one or uses the wrong bit order would report the wrong device in those cases. It also sets several bits at once, with some in the mapping half and some in the access half, where a highest-bit-wins encoder would report the higher slot. An empty field, a type-1 request, misaligned halfword and word accesses, and size code 3 must each suppress both strobes and return a width-correct all-ones read. A design that let any of these through would start a bus cycle, or would return 32 ones for a byte read. Back-to-back requests with different mappings check that each result belongs to its own request and is not shifted by a cycle.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
    localparam int ACC_AW    = 16;
    localparam int MAP_W     = ACC_AW + 1;
    localparam int CFG_W     = 32;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int BUS_W     = 8;
    localparam int SEL_LSB   = 11;
    localparam int SEL_W     = CFG_W - SEL_LSB;
    localparam int DEV_W     = $clog2(SEL_W);
    localparam int FN_LSB    = 8;
    localparam int FN_W      = SEL_LSB - FN_LSB;
    localparam int REG_W     = FN_LSB - 2;
    localparam int TYPE1_BIT = ACC_AW;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic [BE_W-1:0]  be;
        logic             ok;
    } xl_result_t;
endpackage

// File: rtl/pci_cfg_lowbit_enc.sv
module pci_cfg_lowbit_enc #(
    parameter int W  = 21,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [W:0]   clear_below;
    logic [W-1:0] hit;

    assign clear_below[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_chain
            assign hit[g]           = vec[g] & clear_below[g];
            assign clear_below[g+1] = clear_below[g] & ~vec[g];
        end
    endgenerate

    assign any = ~clear_below[W];

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (hit[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
    import pci_cfg_pkg::*;
(
    input  logic [ACC_AW-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [MAP_W-1:0]  map_val,
    input  logic [BUS_W-1:0]  bus_id,
    output xl_result_t        res
);
    logic [CFG_W-1:0] joined;
    logic [DEV_W-1:0] dev;
    logic             sel_any;
    logic             size_ok;
    logic [BE_W-1:0]  lanes;

    assign joined = {map_val[ACC_AW-1:0], acc_addr};

    pci_cfg_lowbit_enc #(.W(SEL_W), .IW(DEV_W)) u_enc (
        .vec (joined[CFG_W-1:SEL_LSB]),
        .idx (dev),
        .any (sel_any)
    );

    always_comb begin
        size_ok = 1'b0;
        lanes   = '0;
        unique case (acc_size_e'(acc_size))
            SZ_BYTE: begin
                size_ok = 1'b1;
                lanes   = BE_W'(4'b0001) << acc_addr[1:0];
            end
            SZ_HALF: begin
                size_ok = ~acc_addr[0];
                lanes   = BE_W'(4'b0011) << acc_addr[1:0];
            end
            SZ_WORD: begin
                size_ok = (acc_addr[1:0] == 2'b00);
                lanes   = '1;
            end
            SZ_BAD: begin
                size_ok = 1'b0;
                lanes   = '0;
            end
            default: begin
                size_ok = 1'b0;
                lanes   = '0;
            end
        endcase
    end

    always_comb begin
        res.ok   = sel_any & size_ok & ~map_val[TYPE1_BIT];
        res.be   = res.ok ? lanes : '0;
        res.word = '0;
        res.word[CFG_W-1]                   = 1'b1;
        res.word[16 +: BUS_W]               = bus_id;
        res.word[SEL_LSB +: DEV_W]          = dev;
        res.word[FN_LSB +: FN_W]            = joined[FN_LSB +: FN_W];
        res.word[2 +: REG_W]                = joined[2 +: REG_W];
    end
endmodule

// File: rtl/pci_cfg_rdfill.sv
module pci_cfg_rdfill
    import pci_cfg_pkg::*;
(
    input  logic              ok,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] ones;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: ones = DATA_W'(8'hFF);
            SZ_HALF: ones = DATA_W'(16'hFFFF);
            SZ_WORD: ones = '1;
            SZ_BAD:  ones = '1;
            default: ones = '1;
        endcase
        data_out = ok ? bus_data : ones;
    end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
    import pci_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ACC_AW-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MAP_W-1:0]  map_cfg,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic              cfg_ok,
    output logic [CFG_W-1:0]  cfg_addr,
    output logic [BE_W-1:0]   cfg_be,
    output logic              cfg_wr_en,
    output logic              cfg_rd_en,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] rd_data
);
    xl_state_e         state_q, state_d;
    xl_result_t        dec;
    xl_result_t        res_q;
    logic              wr_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] wdata_q;

    pci_cfg_decode u_dec (
        .acc_addr (req_addr),
        .acc_size (req_size),
        .map_val  (map_cfg),
        .bus_id   (bus_num),
        .res      (dec)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            wr_q    <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
        end else if (req_valid) begin
            res_q   <= dec;
            wr_q    <= req_write;
            size_q  <= req_size;
            wdata_q <= req_wdata;
        end
    end

    pci_cfg_rdfill u_fill (
        .ok       (res_q.ok),
        .size     (size_q),
        .bus_data (bus_rdata),
        .data_out (rd_data)
    );

    always_comb begin
        rsp_valid = 1'b0;
        cfg_ok    = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_rd_en = 1'b0;
        cfg_addr  = res_q.word;
        cfg_be    = res_q.be;
        cfg_wdata = wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                cfg_ok    = res_q.ok;
                cfg_wr_en = res_q.ok & wr_q;
                cfg_rd_en = res_q.ok & ~wr_q;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk
    import pci_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ACC_AW-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic [MAP_W-1:0]  map_cfg,
    input logic              rsp_valid,
    input logic              cfg_ok,
    input logic [CFG_W-1:0]  cfg_addr,
    input logic              cfg_wr_en,
    input logic              cfg_rd_en,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] rd_data
);
    a_r7_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !cfg_wr_en && !cfg_rd_en));

    a_r2_type1_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[TYPE1_BIT]) |=> !cfg_ok);

    a_r5_empty_select: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[ACC_AW-1:0] == '0 && req_addr[ACC_AW-1:SEL_LSB] == '0)
        |=> !cfg_ok);

    a_r9_no_bad_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !cfg_ok) |-> (!cfg_wr_en && !cfg_rd_en));

    a_r6_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cfg_ok) |-> (cfg_addr[CFG_W-1] && cfg_addr[1:0] == 2'b00));

    a_r11_write_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (cfg_wdata == $past(req_wdata)));

    a_r8_bad_size_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd3) |=> (rd_data == '1));
endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .map_cfg   (map_cfg),
    .rsp_valid (rsp_valid),
    .cfg_ok    (cfg_ok),
    .cfg_addr  (cfg_addr),
    .cfg_wr_en (cfg_wr_en),
    .cfg_rd_en (cfg_rd_en),
    .cfg_wdata (cfg_wdata),
    .rd_data   (rd_data)
);

// File: tb/pci_cfg_xlate_test.sv
module pci_cfg_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BUS_RD = 32'hA5C3_1E7F;
    localparam logic [7:0]  BUSN   = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [16:0] map_cfg = '0;
    logic [7:0]  bus_num = BUSN;
    logic [31:0] bus_rdata = BUS_RD;
    logic        rsp_valid, cfg_ok, cfg_wr_en, cfg_rd_en;
    logic [31:0] cfg_addr, cfg_wdata, rd_data;
    logic [3:0]  cfg_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic        ok;
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] rdata;
        logic [31:0] wdata;
        string       tag;
    } exp_t;

    exp_t sb[$];

    pci_cfg_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .map_cfg(map_cfg), .bus_num(bus_num), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .cfg_ok(cfg_ok), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_wdata(cfg_wdata),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(logic w, logic [15:0] a, logic [1:0] sz,
                                   logic [16:0] m, logic [31:0] wd, string tag);
        exp_t e;
        logic [31:0] full;
        logic [31:0] mask;
        int dev;
        bit found;
        full = {m[15:0], a};
        e.ok = 1'b1;
        dev = 0;
        found = 0;
        for (int b = 11; b < 32; b++) begin
            if (!found && full[b]) begin
                found = 1;
                dev = b - 11;
            end
        end
        if (!found) e.ok = 1'b0;
        if (m[16]) e.ok = 1'b0;
        case (sz)
            2'd0: begin e.be = 4'b0001 << a[1:0]; mask = 32'h0000_00FF; end
            2'd1: begin e.be = 4'b0011 << a[1:0]; mask = 32'h0000_FFFF;
                        if (a[0]) e.ok = 1'b0; end
            2'd2: begin e.be = 4'hF; mask = 32'hFFFF_FFFF;
                        if (a[1:0] != 2'b00) e.ok = 1'b0; end
            default: begin e.be = 4'h0; mask = 32'hFFFF_FFFF; e.ok = 1'b0; end
        endcase
        if (!e.ok) e.be = 4'h0;
        e.addr = 32'h8000_0000 | (32'(BUSN) << 16) | (32'(dev) << 11)
               | (32'(full[10:8]) << 8) | (32'(full[7:2]) << 2);
        e.rdata = e.ok ? BUS_RD : mask;
        e.wr = w;
        e.wdata = wd;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic w, logic [15:0] a, logic [1:0] sz,
                         logic [16:0] m, logic [31:0] wd, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_size  = sz;
        map_cfg   = m;
        req_wdata = wd;
        sb.push_back(model(w, a, sz, m, wd, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R7 actual=unexpected response expected=none");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " ok"}, {31'd0, cfg_ok}, {31'd0, e.ok});
                    chk({e.tag, " R10 be"}, {28'd0, cfg_be}, {28'd0, e.be});
                    chk({e.tag, " R9 wr_en"}, {31'd0, cfg_wr_en}, {31'd0, e.ok & e.wr});
                    chk({e.tag, " R9 rd_en"}, {31'd0, cfg_rd_en}, {31'd0, e.ok & ~e.wr});
                    if (e.ok) chk({e.tag, " R6 addr"}, cfg_addr, e.addr);
                    if (!e.wr) chk({e.tag, " R8 rdata"}, rd_data, e.rdata);
                    if (e.ok && e.wr) chk({e.tag, " R11 wdata"}, cfg_wdata, e.wdata);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12 reset wr_en", {31'd0, cfg_wr_en}, 32'd0);
        chk("R12 reset rd_en", {31'd0, cfg_rd_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        drive(1'b0, 16'h0108, 2'd2, 17'h00002, 32'h0, "R1 R3 select in map half");
        idle(1);
        drive(1'b0, 16'h0800, 2'd2, 17'h00000, 32'h0, "R3 device 0");
        drive(1'b0, 16'h0004, 2'd2, 17'h08000, 32'h0, "R3 device 20");
        drive(1'b0, 16'h2754, 2'd2, 17'h00030, 32'h0, "R4 several bits");
        drive(1'b0, 16'h0000, 2'd2, 17'h00030, 32'h0, "R4 bits only in map half");
        idle(1);
        drive(1'b0, 16'h0020, 2'd0, 17'h00000, 32'h0, "R5 empty select byte");
        drive(1'b0, 16'h0022, 2'd1, 17'h00000, 32'h0, "R5 empty select half");
        drive(1'b1, 16'h0800, 2'd2, 17'h10001, 32'hDEAD_BEEF, "R2 type1 write");
        drive(1'b0, 16'h1000, 2'd2, 17'h10000, 32'h0, "R2 type1 read");
        drive(1'b0, 16'h4001, 2'd1, 17'h00000, 32'h0, "R10 misaligned half");
        drive(1'b0, 16'h4002, 2'd2, 17'h00000, 32'h0, "R10 misaligned word");
        drive(1'b0, 16'h4000, 2'd3, 17'h00000, 32'h0, "R10 size code 3");
        drive(1'b0, 16'h4003, 2'd0, 17'h00000, 32'h0, "R10 R11 byte lane 3");
        drive(1'b0, 16'h4002, 2'd1, 17'h00000, 32'h0, "R10 R11 half upper");
        drive(1'b1, 16'h8A7F, 2'd0, 17'h00000, 32'h1234_5678, "R11 byte write");
        drive(1'b1, 16'hF3FC, 2'd2, 17'h0FFFF, 32'hCAFE_0001, "R11 R6 word write");
        drive(1'b1, 16'h0000, 2'd2, 17'h00000, 32'h5555_AAAA, "R9 dropped write");
        idle(3);
        #(CLK_PERIOD/4);
        chk("R7 idle after burst", {31'd0, rsp_valid}, 32'd0);
        chk("R7 scoreboard drained", sb.size(), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule